// File: doc/BRIEF.md
# Byte-Wide Bridge to 16-Bit Timer Registers

This block lets an 8-bit processor bus reach the 16-bit registers of a timer: the running count, a capture register and a set of compare registers. Every word is reached through two byte addresses. A single 8-bit holding register is shared by all of them and carries the high byte across the two accesses.

Writing a high byte only parks that byte in the holding register. Writing the low byte then loads the parked byte and the new low byte into the chosen word on one clock edge. Reading the low byte of the count or the capture word copies that word's high byte into the holding register on the same edge. A later high-byte read returns that copy, so the two bytes always belong to the same instant even while the counter keeps running. Compare words never change on their own, so their reads skip the holding register.

The block holds the words itself. The count advances on an increment input. A capture trigger loads the capture word from the count. All words are driven out to the rest of the timer.

Top module: `wide_reg_bridge`

## Requirements
- R1: While reset is asserted, and until the first bus access after it, the count, capture and compare words and the holding register are all zero.
- R2: `bus_addr[0]` selects the byte (1 = high, 0 = low). `bus_addr[SELW:1]` selects the word: 0 is the count, 1 is the capture word, and 2+k is compare word k. Any other select is unmapped: a write there changes neither the holding register nor any word, and a read returns zero.
- R3: A high-byte write to a mapped select loads only the holding register. No 16-bit word changes on that edge.
- R4: A low-byte write to a mapped select loads {holding register, write data} into that word on that one edge. The holding register is shared, so a high byte written through any mapped select is the one used.
- R5: When a count low-byte write and an increment fall on the same edge, the written value is loaded and the increment of that cycle is dropped.
- R6: A low-byte read of the count or the capture word returns its live low byte in the cycle of the strobe. On that same edge the word's high byte is copied into the holding register.
- R7: A high-byte read of the count or the capture word returns the holding register, not the live high byte.
- R8: Reads of a compare word return both bytes straight from the word and leave the holding register unchanged.
- R9: The count rises by one on each edge with `cnt_inc` high and no count write, and wraps from 0xFFFF to 0x0000.
- R10: A capture trigger loads the capture word from the count. A capture low-byte write on the same edge wins over the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | SELW+1 | Word select in the upper bits, byte select in bit 0 |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | DW | Write byte |
| bus_rdata | output | DW | Read byte, valid in the cycle of `bus_rd`, zero otherwise |
| cnt_inc | input | 1 | Count increment enable |
| cap_trig | input | 1 | Capture event: load the capture word from the count |
| cnt_q | output | 2*DW | Count word |
| cap_q | output | 2*DW | Capture word |
| cmp_q | output | NUM_CMP*2*DW | Compare words, word k in bits k*2*DW upward |

## Verification
The bench uses the defaults, DW = 8 and NUM_CMP = 3. That gives a 3-bit word select with five mapped words and three unmapped codes (5 to 7), so ignored accesses can be checked next to real ones. The 16-bit count is small enough that the 0xFFFF wrap is reached with a single increment after loading it. The bench keeps the counter running across a 0x01FE to 0x0200 carry while it reads the count, which shows that the high byte is returned from the snapshot and not from the live word.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CNT  = 2'd1,
    TGT_CAP  = 2'd2,
    TGT_CMP  = 2'd3
  } tgt_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode #(
  parameter int NUM_CMP = 3,
  parameter int SELW    = 3,
  parameter int CIW     = 2
) (
  input  logic [SELW:0]       addr,
  output wrb_pkg::tgt_e       tgt,
  output logic [CIW-1:0]      cmp_idx,
  output logic                hi
);
  logic [SELW-1:0] sel;

  assign sel = addr[SELW:1];
  assign hi  = addr[0];

  always_comb begin
    cmp_idx = CIW'(sel - SELW'(2));
    if (sel == SELW'(0))                 tgt = wrb_pkg::TGT_CNT;
    else if (sel == SELW'(1))            tgt = wrb_pkg::TGT_CAP;
    else if (int'(sel) < NUM_CMP + 2)    tgt = wrb_pkg::TGT_CMP;
    else                                 tgt = wrb_pkg::TGT_NONE;
  end
endmodule

// File: rtl/wrb_hold.sv
module wrb_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] hold_q
);
  logic [DW-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (ld_en) hold_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/wrb_regs.sv
module wrb_regs #(
  parameter int DW      = 8,
  parameter int NUM_CMP = 3,
  parameter int CIW     = 2,
  localparam int WW     = 2 * DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  wrb_pkg::tgt_e         tgt,
  input  logic [CIW-1:0]        cmp_idx,
  input  logic [WW-1:0]         wval,
  input  logic                  cnt_inc,
  input  logic                  cap_trig,
  output logic [WW-1:0]         cnt_q,
  output logic [WW-1:0]         cap_q,
  output logic [NUM_CMP*WW-1:0] cmp_q
);
  logic [WW-1:0] cnt_d, cap_d;

  // The bus write comes first, so an increment in the same cycle is dropped
  always_comb begin
    cnt_d = cnt_q;
    if (commit && tgt == wrb_pkg::TGT_CNT) cnt_d = wval;
    else if (cnt_inc)                      cnt_d = cnt_q + WW'(1);
  end

  always_comb begin
    cap_d = cap_q;
    if (commit && tgt == wrb_pkg::TGT_CAP) cap_d = wval;
    else if (cap_trig)                     cap_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic          we;
    logic [WW-1:0] word_d, word_q;

    assign we = commit && (tgt == wrb_pkg::TGT_CMP) && (cmp_idx == CIW'(g));

    always_comb begin
      word_d = word_q;
      if (we) word_d = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign cmp_q[g*WW +: WW] = word_q;
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int  DW      = 8,
  parameter int  NUM_CMP = 3,
  localparam int WW      = 2 * DW,
  localparam int SELW    = $clog2(NUM_CMP + 2),
  localparam int CIW     = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SELW:0]         bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic                  cnt_inc,
  input  logic                  cap_trig,
  output logic [WW-1:0]         cnt_q,
  output logic [WW-1:0]         cap_q,
  output logic [NUM_CMP*WW-1:0] cmp_q
);
  // Reset: asserted at once, released on a clock edge through two flops
  logic rst_meta, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  wrb_pkg::tgt_e  tgt;
  logic [CIW-1:0] cmp_idx;
  logic           hi;

  wrb_decode #(.NUM_CMP(NUM_CMP), .SELW(SELW), .CIW(CIW)) u_dec (
    .addr    (bus_addr),
    .tgt     (tgt),
    .cmp_idx (cmp_idx),
    .hi      (hi)
  );

  logic          mapped, live_tgt;
  logic [WW-1:0] sel_word;

  assign mapped   = (tgt != wrb_pkg::TGT_NONE);
  assign live_tgt = (tgt == wrb_pkg::TGT_CNT) || (tgt == wrb_pkg::TGT_CAP);

  always_comb begin
    case (tgt)
      wrb_pkg::TGT_CNT: sel_word = cnt_q;
      wrb_pkg::TGT_CAP: sel_word = cap_q;
      wrb_pkg::TGT_CMP: sel_word = cmp_q[int'(cmp_idx)*WW +: WW];
      default:          sel_word = '0;
    endcase
  end

  // Holding register: parked by high writes, snapshot by live low reads
  logic          hold_ld;
  logic [DW-1:0] hold_val, hold_q;

  always_comb begin
    hold_ld  = 1'b0;
    hold_val = bus_wdata;
    if (bus_wr && hi && mapped) begin
      hold_ld = 1'b1;
    end else if (bus_rd && !bus_wr && !hi && live_tgt) begin
      hold_ld  = 1'b1;
      hold_val = sel_word[WW-1:DW];
    end
  end

  wrb_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .ld_en  (hold_ld),
    .ld_val (hold_val),
    .hold_q (hold_q)
  );

  logic commit;
  assign commit = bus_wr && !hi && mapped;

  wrb_regs #(.DW(DW), .NUM_CMP(NUM_CMP), .CIW(CIW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .commit   (commit),
    .tgt      (tgt),
    .cmp_idx  (cmp_idx),
    .wval     ({hold_q, bus_wdata}),
    .cnt_inc  (cnt_inc),
    .cap_trig (cap_trig),
    .cnt_q    (cnt_q),
    .cap_q    (cap_q),
    .cmp_q    (cmp_q)
  );

  // Read path: live high bytes are never returned for count or capture
  always_comb begin
    bus_rdata = '0;
    if (bus_rd && mapped) begin
      if (!hi)           bus_rdata = sel_word[DW-1:0];
      else if (live_tgt) bus_rdata = hold_q;
      else               bus_rdata = sel_word[WW-1:DW];
    end
  end
endmodule

// File: rtl/wrb_chk.sv
module wrb_chk #(
  parameter int  DW      = 8,
  parameter int  NUM_CMP = 3,
  localparam int WW      = 2 * DW,
  localparam int SELW    = $clog2(NUM_CMP + 2)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SELW:0]         bus_addr,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [DW-1:0]         bus_wdata,
  input logic [DW-1:0]         hold_q,
  input logic                  cnt_inc,
  input logic                  cap_trig,
  input logic [WW-1:0]         cnt_q,
  input logic [WW-1:0]         cap_q,
  input logic [NUM_CMP*WW-1:0] cmp_q
);
  logic [SELW-1:0] sel;
  logic            cnt_lo_wr, cmp_sel;

  assign sel       = bus_addr[SELW:1];
  assign cnt_lo_wr = bus_wr && !bus_addr[0] && (sel == SELW'(0));
  assign cmp_sel   = (sel >= SELW'(2)) && (int'(sel) < NUM_CMP + 2);

  // R3
  hi_write_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0] && !cap_trig) |=> ($stable(cmp_q) && $stable(cap_q)));

  // R5
  cnt_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lo_wr |=> (cnt_q == {$past(hold_q), $past(bus_wdata)}));

  // R6
  cnt_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_addr[0] && sel == SELW'(0))
      |=> (hold_q == $past(cnt_q[WW-1:DW])));

  // R8
  cmp_read_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && cmp_sel) |=> $stable(hold_q));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !cnt_lo_wr) |=> (cnt_q == WW'($past(cnt_q) + WW'(1))));
endmodule

bind wide_reg_bridge wrb_chk #(.DW(DW), .NUM_CMP(NUM_CMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .hold_q    (hold_q),
  .cnt_inc   (cnt_inc),
  .cap_trig  (cap_trig),
  .cnt_q     (cnt_q),
  .cap_q     (cap_q),
  .cmp_q     (cmp_q)
);

// File: tb/wide_reg_bridge_tb.sv
module wide_reg_bridge_tb;
  localparam int DW = 8;
  localparam int NUM_CMP = 3;
  localparam int WW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              cnt_inc = 1'b0, cap_trig = 1'b0;
  logic [15:0]       cnt_q, cap_q;
  logic [47:0]       cmp_q;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wide_reg_bridge #(.DW(DW), .NUM_CMP(NUM_CMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_inc(cnt_inc), .cap_trig(cap_trig), .cnt_q(cnt_q),
    .cap_q(cap_q), .cmp_q(cmp_q)
  );

  function automatic logic [3:0] ad(int sel, bit hi);
    return {sel[2:0], hi};
  endfunction

  function automatic logic [15:0] cmpw(int k);
    return cmp_q[k*WW +: WW];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h, expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_inc();
    @(negedge clk); cnt_inc = 1'b1;
    @(negedge clk); cnt_inc = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", cnt_q, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 count", cnt_q, 16'h0000);
    chk("R1 capture", cap_q, 16'h0000);
    chk("R1 compare0", cmpw(0), 16'h0000);
    bus_read(ad(0, 1), v);
    chk("R1 holding via count high read", {8'h00, v}, 16'h0000);
  endtask

  task automatic t_cmp_write();
    bus_write(ad(3, 1), 8'hA5);
    chk("R3 compare1 after high write", cmpw(1), 16'h0000);
    chk("R3 count after high write", cnt_q, 16'h0000);
    chk("R3 capture after high write", cap_q, 16'h0000);
    bus_write(ad(3, 0), 8'h5A);
    chk("R4 compare1 committed", cmpw(1), 16'hA55A);
    chk("R4 compare0 untouched", cmpw(0), 16'h0000);
  endtask

  task automatic t_shared_hold();
    logic [7:0] v;
    bus_write(ad(2, 1), 8'h12);
    bus_write(ad(4, 0), 8'h34);
    chk("R4 shared holding into compare2", cmpw(2), 16'h1234);
    chk("R3 compare0 unchanged", cmpw(0), 16'h0000);
    bus_read(ad(4, 1), v);
    chk("R8 compare2 high direct", {8'h00, v}, 16'h0012);
    bus_read(ad(4, 0), v);
    chk("R8 compare2 low", {8'h00, v}, 16'h0034);
  endtask

  task automatic t_count_coherent();
    logic [7:0] lo, hi;
    @(negedge clk); cnt_inc = 1'b1;
    bus_write(ad(0, 1), 8'h01);
    bus_write(ad(0, 0), 8'hFE);
    chk("R5 write beats increment", cnt_q, 16'h01FE);
    bus_read(ad(0, 0), lo);
    chk("R6 live low byte", {8'h00, lo}, 16'h00FF);
    bus_read(ad(0, 1), hi);
    chk("R7 snapshot high byte", {8'h00, hi}, 16'h0001);
    chk("R9 counter kept running", cnt_q, 16'h0202);
    @(negedge clk); cnt_inc = 1'b0;
  endtask

  task automatic t_cmp_bypass();
    logic [7:0] v;
    bus_write(ad(0, 1), 8'h77);
    bus_write(ad(0, 0), 8'hFF);
    chk("R4 count loaded", cnt_q, 16'h77FF);
    bus_read(ad(0, 0), v);
    pulse_inc();
    chk("R9 carry into high byte", cnt_q, 16'h7800);
    bus_read(ad(3, 0), v);
    chk("R8 compare1 low", {8'h00, v}, 16'h005A);
    bus_read(ad(3, 1), v);
    chk("R8 compare1 high direct", {8'h00, v}, 16'h00A5);
    bus_read(ad(0, 1), v);
    chk("R8 holding kept by compare reads", {8'h00, v}, 16'h0077);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    @(negedge clk); cap_trig = 1'b1;
    @(negedge clk); cap_trig = 1'b0;
    chk("R10 capture from count", cap_q, 16'h7800);
    bus_read(ad(1, 0), v);
    chk("R6 capture low", {8'h00, v}, 16'h0000);
    bus_read(ad(1, 1), v);
    chk("R7 capture high from holding", {8'h00, v}, 16'h0078);
    bus_write(ad(1, 1), 8'hBE);
    @(negedge clk);
    bus_addr = ad(1, 0); bus_wdata = 8'hEF; bus_wr = 1'b1; cap_trig = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cap_trig = 1'b0;
    chk("R10 bus write beats trigger", cap_q, 16'hBEEF);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    bus_write(ad(2, 1), 8'h11);
    bus_write(ad(6, 1), 8'h99);
    bus_write(ad(7, 0), 8'h55);
    chk("R2 count after unmapped writes", cnt_q, 16'h7800);
    chk("R2 compare1 after unmapped writes", cmpw(1), 16'hA55A);
    chk("R2 compare2 after unmapped writes", cmpw(2), 16'h1234);
    bus_write(ad(2, 0), 8'h22);
    chk("R2 holding kept across unmapped high write", cmpw(0), 16'h1122);
    bus_read(ad(5, 0), v);
    chk("R2 unmapped low read", {8'h00, v}, 16'h0000);
    bus_read(ad(6, 1), v);
    chk("R2 unmapped high read", {8'h00, v}, 16'h0000);
  endtask

  task automatic t_wrap();
    bus_write(ad(0, 1), 8'hFF);
    bus_write(ad(0, 0), 8'hFF);
    chk("R4 count at max", cnt_q, 16'hFFFF);
    pulse_inc();
    chk("R9 wrap to zero", cnt_q, 16'h0000);
    pulse_inc();
    chk("R9 step after wrap", cnt_q, 16'h0001);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_cmp_write();
    t_shared_hold();
    t_count_coherent();
    t_cmp_bypass();
    t_capture();
    t_unmapped();
    t_wrap();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
  end
endmodule